// File: doc/BRIEF.md
# Per-Link Cell Capture Filter

This block watches a byte-serial stream of fixed-length cells (53 bytes by default) arriving from up to sixteen physical links. Each cell begins with a start marker. On that first byte the block samples the cell's link number, a valid flag and a control-cell flag. For every completed cell, the block decides whether the cell is forwarded to a shared capture buffer that sits downstream. The decision uses a 2-bit capture policy held for each link. One policy keeps only control cells whose content has changed since the last cell kept on that link. The other policies keep all control cells, keep every valid cell, or keep nothing.

For each link the block holds a reference copy of the last cell it kept. Every byte is compared with the reference as the byte arrives. When a link's change-report enable is set, a forwarded cell comes with a per-byte mask that shows which bytes differ from that reference. A small register port sets the policies and the enables. Settings are sampled on a cell's first byte, so a register write never alters a cell that is already in progress.

Top module: `ccf_capture_filter`

## Requirements
- R1: After reset, every register reads zero (all links use policy 00, all change reports are disabled), and `out_wr` is low.
- R2: Register address 0 holds the policies of links 0-7 and address 1 holds those of links 8-15. Link n uses bits [2(n mod 8)+1 : 2(n mod 8)]. Address 2 holds the change-report enable of link n in bit n. Address 3 reads as zero. Each register reads back the value written.
- R3: Policy 00 forwards a valid control cell only if at least one byte differs from the reference of its link. A link with no reference since reset counts as changed. Non-control cells are not forwarded.
- R4: Policy 01 forwards every valid control cell and no non-control cell.
- R5: Policy 10 forwards every valid cell, whatever its control flag.
- R6: Policy 11 forwards no cell.
- R7: A cell whose valid flag is low is never forwarded, under any policy, and leaves the reference of its link unchanged.
- R8: `out_wr` pulses for one cycle, in the cycle after the last byte of a forwarded cell is accepted. `out_link` then carries the cell's link, and `out_cell` carries byte i in bits [8i+7:8i].
- R9: With the link's enable at 1, bit i of `out_mask` is 1 exactly when byte i differs from the reference (all ones if there is no reference). With the enable at 0, `out_mask` is zero. `out_mask` is zero whenever `out_wr` is low.
- R10: Every forwarded cell, under any policy, replaces the reference of its own link only. References of other links are unaffected.
- R11: The policy and enable used for a cell are those held when its first byte is accepted. A register write during the cell takes effect only from the next cell.
- R12: Bytes with `in_vld` low are skipped. A byte without a start marker outside a cell is ignored. A start marker inside a cell drops the partial cell and begins a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` (combinational) |
| in_vld | input | 1 | A cell byte is present this cycle |
| in_soc | input | 1 | Present byte is the first of a cell |
| in_link | input | 4 | Link number, sampled with the first byte |
| in_cvalid | input | 1 | Cell valid flag, sampled with the first byte |
| in_ctrl | input | 1 | Control-cell flag, sampled with the first byte |
| in_byte | input | 8 | Cell byte |
| out_wr | output | 1 | Forward strobe to the capture buffer |
| out_link | output | 4 | Link of the forwarded cell |
| out_cell | output | 424 | Forwarded cell, byte i at bits [8i+7:8i] |
| out_mask | output | 53 | Changed-byte mask, bit i for byte i |

## Verification
The assertions assume that the start marker only has meaning together with `in_vld`. They also assume the downstream buffer takes every strobe, so `out_wr` is never held off. The bench keeps `in_soc` low whenever `in_vld` is low. It delivers each cell as exactly one marked byte followed by unmarked bytes. The exceptions are deliberate: truncated cells that are cut off by a new marker, and stray unmarked bytes outside a cell. Register writes come from the bench at any point, including inside a cell.

// File: rtl/ccf_pkg.sv
package ccf_pkg;

    typedef enum logic [1:0] {
        CAP_DELTA = 2'b00,
        CAP_CTRL  = 2'b01,
        CAP_ANY   = 2'b10,
        CAP_NONE  = 2'b11
    } cap_mode_e;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_COLLECT = 1'b1
    } col_state_e;

    localparam int          REG_DATA_W    = 16;
    localparam int          LINKS_PER_REG = 8;
    localparam logic [1:0]  ADDR_ENABLE   = 2'd2;

endpackage

// File: rtl/ccf_cfg.sv
module ccf_cfg
    import ccf_pkg::*;
#(
    parameter int NUM_LINKS = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_wr,
    input  logic [1:0]                 reg_addr,
    input  logic [REG_DATA_W-1:0]      reg_wdata,
    output logic [REG_DATA_W-1:0]      reg_rdata,
    output logic [2*NUM_LINKS-1:0]     mode_flat,
    output logic [NUM_LINKS-1:0]       en_vec
);

    // One policy field and one enable bit per link.
    for (genvar l = 0; l < NUM_LINKS; l++) begin : g_link
        localparam logic [1:0] SEL = 2'(l / LINKS_PER_REG);
        localparam int         OFS = (l % LINKS_PER_REG) * 2;

        logic [1:0] mode_r;
        logic       en_r;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mode_r <= 2'b00;
                en_r   <= 1'b0;
            end else if (reg_wr) begin
                if (reg_addr == SEL)
                    mode_r <= reg_wdata[OFS +: 2];
                if (reg_addr == ADDR_ENABLE)
                    en_r <= reg_wdata[l];
            end
        end

        assign mode_flat[2*l +: 2] = mode_r;
        assign en_vec[l]           = en_r;
    end

    always_comb begin
        reg_rdata = '0;
        for (int l = 0; l < NUM_LINKS; l++) begin
            if (reg_addr == 2'(l / LINKS_PER_REG))
                reg_rdata[(l % LINKS_PER_REG)*2 +: 2] = mode_flat[2*l +: 2];
            if (reg_addr == ADDR_ENABLE)
                reg_rdata[l] = en_vec[l];
        end
    end

endmodule

// File: rtl/ccf_ref.sv
module ccf_ref #(
    parameter  int NUM_LINKS  = 16,
    parameter  int CELL_BYTES = 53,
    localparam int LINK_W     = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1,
    localparam int IDX_W      = $clog2(CELL_BYTES),
    localparam int CELL_W     = CELL_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINK_W-1:0] rd_link,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [7:0]        rd_byte,
    output logic              rd_has,
    input  logic              wr_en,
    input  logic [LINK_W-1:0] wr_link,
    input  logic [CELL_W-1:0] wr_cell
);

    logic [7:0]           mem_q [NUM_LINKS][CELL_BYTES];
    logic [NUM_LINKS-1:0] has_q;

    // Whole-row replacement of the link's reference on each forward.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < CELL_BYTES; b++)
                mem_q[wr_link][b] <= wr_cell[8*b +: 8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            has_q <= '0;
        else if (wr_en)
            has_q[wr_link] <= 1'b1;
    end

    assign rd_byte = mem_q[rd_link][rd_idx];
    assign rd_has  = has_q[rd_link];

endmodule

// File: rtl/ccf_collect.sv
module ccf_collect
    import ccf_pkg::*;
#(
    parameter  int NUM_LINKS  = 16,
    parameter  int CELL_BYTES = 53,
    localparam int LINK_W     = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1,
    localparam int IDX_W      = $clog2(CELL_BYTES),
    localparam int CELL_W     = CELL_BYTES * 8,
    localparam int LAST       = CELL_BYTES - 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_vld,
    input  logic                   in_soc,
    input  logic [LINK_W-1:0]      in_link,
    input  logic                   in_cvalid,
    input  logic                   in_ctrl,
    input  logic [7:0]             in_byte,
    input  logic [2*NUM_LINKS-1:0] mode_flat,
    input  logic [NUM_LINKS-1:0]   en_vec,
    output logic [LINK_W-1:0]      rd_link,
    output logic [IDX_W-1:0]       rd_idx,
    input  logic [7:0]             rd_byte,
    input  logic                   rd_has,
    output logic                   wr_en,
    output logic [LINK_W-1:0]      wr_link,
    output logic [CELL_W-1:0]      wr_cell,
    output logic                   out_wr,
    output logic [LINK_W-1:0]      out_link,
    output logic [CELL_W-1:0]      out_cell,
    output logic [CELL_BYTES-1:0]  out_mask,
    output col_state_e             st
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LAST);

    col_state_e              state_q, state_d;
    logic [IDX_W-1:0]        idx_q;
    logic [LINK_W-1:0]       link_q;
    logic                    cvalid_q, ctrl_q, en_q;
    cap_mode_e               mode_q;
    logic [CELL_W-1:0]       buf_q;
    logic [CELL_BYTES-1:0]   diff_q;

    logic                    start, mid, finish, byte_diff, pol, keep;
    logic [IDX_W-1:0]        cur_idx;
    logic [CELL_W-1:0]       cell_full;
    logic [CELL_BYTES-1:0]   diff_full;

    assign start   = in_vld & in_soc;
    assign mid     = (state_q == ST_COLLECT) & in_vld & ~in_soc;
    assign finish  = mid & (idx_q == LAST_IDX);
    assign cur_idx = start ? '0 : idx_q;

    // Reference lookup follows the byte being accepted this cycle.
    assign rd_link   = start ? in_link : link_q;
    assign rd_idx    = cur_idx;
    assign byte_diff = ~rd_has | (rd_byte != in_byte);

    always_comb begin
        cell_full               = buf_q;
        cell_full[LAST*8 +: 8]  = in_byte;
        diff_full               = diff_q;
        diff_full[LAST]         = byte_diff;
        unique case (mode_q)
            CAP_DELTA: pol = ctrl_q & (|diff_full);
            CAP_CTRL:  pol = ctrl_q;
            CAP_ANY:   pol = 1'b1;
            CAP_NONE:  pol = 1'b0;
        endcase
        keep = cvalid_q & pol;
    end

    assign wr_en   = finish & keep;
    assign wr_link = link_q;
    assign wr_cell = cell_full;

    // Next-state logic: IDLE --start--> COLLECT, COLLECT --finish--> IDLE,
    // COLLECT --start--> COLLECT (restart).
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_COLLECT;
            ST_COLLECT: begin
                if (start)       state_d = ST_COLLECT;
                else if (finish) state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            link_q   <= '0;
            cvalid_q <= 1'b0;
            ctrl_q   <= 1'b0;
            en_q     <= 1'b0;
            mode_q   <= CAP_DELTA;
            buf_q    <= '0;
            diff_q   <= '0;
            out_wr   <= 1'b0;
            out_link <= '0;
            out_cell <= '0;
            out_mask <= '0;
        end else begin
            out_wr   <= 1'b0;
            out_mask <= '0;
            if (start) begin
                link_q     <= in_link;
                cvalid_q   <= in_cvalid;
                ctrl_q     <= in_ctrl;
                mode_q     <= cap_mode_e'(mode_flat[2*in_link +: 2]);
                en_q       <= en_vec[in_link];
                idx_q      <= IDX_W'(1);
                buf_q[7:0] <= in_byte;
                diff_q[0]  <= byte_diff;
            end else if (mid) begin
                idx_q                 <= idx_q + IDX_W'(1);
                buf_q[cur_idx*8 +: 8] <= in_byte;
                diff_q[cur_idx]       <= byte_diff;
                if (finish) begin
                    idx_q    <= '0;
                    out_wr   <= keep;
                    out_link <= link_q;
                    out_cell <= cell_full;
                    out_mask <= (keep & en_q) ? diff_full : '0;
                end
            end
        end
    end

    assign st = state_q;

endmodule

// File: rtl/ccf_capture_filter.sv
module ccf_capture_filter
    import ccf_pkg::*;
#(
    parameter  int NUM_LINKS  = 16,
    parameter  int CELL_BYTES = 53,
    localparam int LINK_W     = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1,
    localparam int IDX_W      = $clog2(CELL_BYTES),
    localparam int CELL_W     = CELL_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [1:0]            reg_addr,
    input  logic [15:0]           reg_wdata,
    output logic [15:0]           reg_rdata,
    input  logic                  in_vld,
    input  logic                  in_soc,
    input  logic [LINK_W-1:0]     in_link,
    input  logic                  in_cvalid,
    input  logic                  in_ctrl,
    input  logic [7:0]            in_byte,
    output logic                  out_wr,
    output logic [LINK_W-1:0]     out_link,
    output logic [CELL_W-1:0]     out_cell,
    output logic [CELL_BYTES-1:0] out_mask
);

    logic [2*NUM_LINKS-1:0] mode_flat;
    logic [NUM_LINKS-1:0]   en_vec;
    logic [LINK_W-1:0]      rd_link, wr_link;
    logic [IDX_W-1:0]       rd_idx;
    logic [7:0]             rd_byte;
    logic                   rd_has, wr_en;
    logic [CELL_W-1:0]      wr_cell;
    col_state_e             col_state;

    ccf_cfg #(.NUM_LINKS(NUM_LINKS)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .mode_flat(mode_flat), .en_vec(en_vec)
    );

    ccf_ref #(.NUM_LINKS(NUM_LINKS), .CELL_BYTES(CELL_BYTES)) u_ref (
        .clk(clk), .rst_n(rst_n),
        .rd_link(rd_link), .rd_idx(rd_idx), .rd_byte(rd_byte), .rd_has(rd_has),
        .wr_en(wr_en), .wr_link(wr_link), .wr_cell(wr_cell)
    );

    ccf_collect #(.NUM_LINKS(NUM_LINKS), .CELL_BYTES(CELL_BYTES)) u_col (
        .clk(clk), .rst_n(rst_n),
        .in_vld(in_vld), .in_soc(in_soc), .in_link(in_link),
        .in_cvalid(in_cvalid), .in_ctrl(in_ctrl), .in_byte(in_byte),
        .mode_flat(mode_flat), .en_vec(en_vec),
        .rd_link(rd_link), .rd_idx(rd_idx), .rd_byte(rd_byte), .rd_has(rd_has),
        .wr_en(wr_en), .wr_link(wr_link), .wr_cell(wr_cell),
        .out_wr(out_wr), .out_link(out_link), .out_cell(out_cell),
        .out_mask(out_mask), .st(col_state)
    );

endmodule

// File: rtl/ccf_chk.sv
module ccf_chk
    import ccf_pkg::*;
#(
    parameter int CELL_BYTES = 53
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_vld,
    input logic                  in_soc,
    input logic                  out_wr,
    input logic [CELL_BYTES-1:0] out_mask,
    input col_state_e            st
);

    // R8
    wr_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr |-> ($past(in_vld) && !$past(in_soc) && $past(st) == ST_COLLECT));

    // R8
    wr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr |-> st == ST_IDLE);

    // R9
    mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_wr |-> out_mask == '0);

    // R12
    stray_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !(in_vld && in_soc)) |=> st == ST_IDLE);

    // R12
    soc_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_soc) |=> st == ST_COLLECT);

endmodule

bind ccf_capture_filter ccf_chk #(.CELL_BYTES(CELL_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_soc(in_soc),
    .out_wr(out_wr), .out_mask(out_mask), .st(col_state)
);

// File: tb/sim_ccf_capture_filter.sv
`timescale 1ns/1ps
module sim_ccf_capture_filter;

    localparam int NL = 16;
    localparam int CB = 53;
    localparam int CW = CB * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic          in_vld = 1'b0, in_soc = 1'b0, in_cvalid = 1'b0, in_ctrl = 1'b0;
    logic [3:0]    in_link = '0;
    logic [7:0]    in_byte = '0;
    logic          out_wr;
    logic [3:0]    out_link;
    logic [CW-1:0] out_cell;
    logic [CB-1:0] out_mask;

    always #4 clk = ~clk;

    ccf_capture_filter u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .in_vld(in_vld), .in_soc(in_soc), .in_link(in_link),
        .in_cvalid(in_cvalid), .in_ctrl(in_ctrl), .in_byte(in_byte),
        .out_wr(out_wr), .out_link(out_link), .out_cell(out_cell),
        .out_mask(out_mask)
    );

    int checks = 0, errors = 0, seen_wr = 0, exp_wr_cnt = 0;
    bit done = 0;

    logic [CW-1:0] mref [NL];
    bit            mhas [NL];
    logic [1:0]    mmode [NL];
    bit            men [NL];

    always @(negedge clk) if (rst_n && out_wr) seen_wr++;

    task automatic check(input string req, input string what,
                         input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic void apply_reg(input logic [1:0] a, input logic [15:0] d);
        for (int l = 0; l < NL; l++) begin
            if (a == 2'(l / 8)) mmode[l] = d[(l % 8)*2 +: 2];
            if (a == 2'd2)      men[l]   = d[l];
        end
    endfunction

    task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
        apply_reg(a, d);
    endtask

    task automatic rd_reg(input logic [1:0] a, input logic [15:0] exp, input string req);
        reg_addr = a;
        #1;
        check(req, "register readback", 512'(reg_rdata), 512'(exp));
    endtask

    function automatic logic [CW-1:0] rand_cell();
        logic [CW-1:0] v;
        for (int i = 0; i < CB; i++) v[8*i +: 8] = 8'($urandom);
        return v;
    endfunction

    // Sends one full cell and checks the forward cycle against the model.
    task automatic send_cell(input int l, input bit cv, input bit ct,
                             input logic [CW-1:0] v, input int gap_pct,
                             input bit inj, input logic [1:0] ia,
                             input logic [15:0] id, input string req);
        logic [1:0]    md;
        bit            en, keep, any;
        logic [CB-1:0] d;
        md = mmode[l];
        en = men[l];
        for (int i = 0; i < CB; i++)
            d[i] = !mhas[l] || (mref[l][8*i +: 8] != v[8*i +: 8]);
        any  = |d;
        keep = cv && ((md == 2'b00) ? (ct && any) :
                      (md == 2'b01) ? ct : (md == 2'b10));
        for (int i = 0; i < CB; i++) begin
            in_vld = 1; in_soc = (i == 0); in_byte = v[8*i +: 8];
            in_link = 4'(l); in_cvalid = cv; in_ctrl = ct;
            reg_wr = inj && (i == 20); reg_addr = ia; reg_wdata = id;
            @(negedge clk);
            reg_wr = 0;
            if (i != CB-1 && i != 0 && $urandom_range(99) < gap_pct) begin
                in_vld = 0; in_soc = 0; in_byte = 8'($urandom);
                @(negedge clk);
            end
        end
        in_vld = 0; in_soc = 0;
        check(req, "out_wr", 512'(out_wr), 512'(keep));
        check("R9", "out_mask", 512'(out_mask), 512'((keep && en) ? d : '0));
        if (keep) begin
            check("R8", "out_link", 512'(out_link), 512'(l));
            check("R8", "out_cell", 512'(out_cell), 512'(v));
            mref[l] = v;
            mhas[l] = 1;
            exp_wr_cnt++;
        end
        if (inj) apply_reg(ia, id);
    endtask

    task automatic send_partial(input int l, input int n);
        for (int i = 0; i < n; i++) begin
            in_vld = 1; in_soc = (i == 0); in_byte = 8'($urandom);
            in_link = 4'(l); in_cvalid = 1; in_ctrl = 1;
            @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual run still busy, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [CW-1:0] a, b;
        void'($urandom(32'd20240611));
        for (int l = 0; l < NL; l++) begin
            mref[l] = '0; mhas[l] = 0; mmode[l] = 2'b00; men[l] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        rd_reg(2'd0, 16'h0000, "R1");
        rd_reg(2'd1, 16'h0000, "R1");
        rd_reg(2'd2, 16'h0000, "R1");
        check("R1", "out_wr after reset", 512'(out_wr), 512'(0));

        // R2 register map readback
        wr_reg(2'd0, 16'h1B6C);
        wr_reg(2'd1, 16'hE4D2);
        wr_reg(2'd2, 16'hA5F0);
        rd_reg(2'd0, 16'h1B6C, "R2");
        rd_reg(2'd1, 16'hE4D2, "R2");
        rd_reg(2'd2, 16'hA5F0, "R2");
        rd_reg(2'd3, 16'h0000, "R2");
        wr_reg(2'd0, 16'h0000);
        wr_reg(2'd1, 16'h000C);   // link 9 -> policy 11, link 8 -> 00
        wr_reg(2'd2, 16'h0001);   // change report on link 0

        // R2 / R6 field position: link 9 drops, link 8 keeps first cell
        send_cell(9, 1, 1, rand_cell(), 0, 0, 0, 0, "R6");
        send_cell(8, 1, 1, rand_cell(), 0, 0, 0, 0, "R2");

        // R3 change-only policy on link 0
        a = rand_cell();
        send_cell(0, 1, 1, a, 0, 0, 0, 0, "R3");
        send_cell(0, 1, 1, a, 0, 0, 0, 0, "R3");
        b = a; b[8*5 +: 8] = ~b[8*5 +: 8];
        send_cell(0, 1, 1, b, 0, 0, 0, 0, "R3");
        send_cell(0, 1, 0, rand_cell(), 0, 0, 0, 0, "R3");

        // R7 invalid cell neither forwarded nor updating reference
        send_cell(0, 0, 1, rand_cell(), 0, 0, 0, 0, "R7");
        send_cell(0, 1, 1, b, 0, 0, 0, 0, "R7");

        // R4 all control cells on link 1
        wr_reg(2'd0, 16'h0004);
        a = rand_cell();
        send_cell(1, 1, 1, a, 0, 0, 0, 0, "R4");
        send_cell(1, 1, 1, a, 0, 0, 0, 0, "R4");
        send_cell(1, 1, 0, a, 0, 0, 0, 0, "R4");

        // R5 all valid cells on link 2, then R10 reference from non-control cell
        wr_reg(2'd0, 16'h0024);
        a = rand_cell();
        send_cell(2, 1, 0, a, 0, 0, 0, 0, "R5");
        send_cell(2, 1, 0, a, 0, 0, 0, 0, "R5");
        send_cell(2, 0, 1, rand_cell(), 0, 0, 0, 0, "R7");
        wr_reg(2'd0, 16'h0004);
        send_cell(2, 1, 1, a, 0, 0, 0, 0, "R10");
        send_cell(4, 1, 1, b, 0, 0, 0, 0, "R10");

        // R11 mid-cell policy change on link 3
        wr_reg(2'd0, 16'h0084);
        send_cell(3, 1, 0, rand_cell(), 0, 1, 2'd0, 16'h00C4, "R11");
        send_cell(3, 1, 0, rand_cell(), 0, 0, 0, 0, "R11");

        // R12 truncated cell, stray bytes, gaps
        send_partial(5, 10);
        send_cell(5, 1, 1, rand_cell(), 0, 0, 0, 0, "R12");
        for (int i = 0; i < 3; i++) begin
            in_vld = 1; in_soc = 0; in_byte = 8'($urandom);
            @(negedge clk);
        end
        in_vld = 0;
        @(negedge clk);
        check("R12", "stray bytes forward nothing", 512'(out_wr), 512'(0));
        send_cell(6, 1, 1, rand_cell(), 30, 0, 0, 0, "R12");

        // Random traffic
        for (int n = 0; n < 400; n++) begin
            int l, r;
            logic [CW-1:0] v;
            if ($urandom_range(9) == 0)
                wr_reg(2'($urandom_range(2)), 16'($urandom));
            l = $urandom_range(NL-1);
            r = $urandom_range(2);
            v = (r == 2 || !mhas[l]) ? rand_cell() : mref[l];
            if (r == 1) begin
                int p;
                p = $urandom_range(CB-1);
                v[8*p +: 8] = v[8*p +: 8] ^ 8'($urandom_range(255, 1));
            end
            send_cell(l, $urandom_range(99) < 85, $urandom_range(1) == 1, v,
                      10, $urandom_range(19) == 0, 2'($urandom_range(2)),
                      16'($urandom), "R3");
        end

        @(negedge clk);
        check("R6", "total forwards", 512'(seen_wr), 512'(exp_wr_cnt));
        done = 1;
        summary();
        $finish;
    end

endmodule